// File: doc/BRIEF.md
# Sequential Shift-Add Floating-Point Multiplier

This block forms the product of two floating-point operands that have already been unpacked. Each operand has a two-bit class, a sign, a signed unbiased exponent and a fixed-point mantissa. The mantissa is `MANT_W` bits wide. Its integer bit sits at position `MANT_W-1` and its lowest `GR_W` bits are guard/round bits. Operand classes are ranked. When either operand is not an ordinary number, the result is chosen from a fixed precedence and is ready one clock after `start`.

When both operands are numbers, the multiplier mantissa is taken as 32-bit words, from the least significant word upward. A word that is entirely zero, other than the top word, costs a single cycle. Every other word is consumed one bit per cycle with a shift-right-and-conditionally-add step. Stepping stops once the mantissa's leading bit has been consumed. A final cycle shifts the product right by at most one position and adjusts the exponent.

No bit of the product is lost without being recorded. Every bit shifted out is ORed into a sticky flag that goes out with the result, so a downstream rounder can finish the job.

Top module: `fp_shiftadd_mul`

## Requirements
- R1: Class codes are zero=0, number=1, infinity=2, NaN=3, and a higher code has higher precedence. Operands are ordered so that the higher-precedence one becomes the primary operand; when the codes are equal, operand b is primary. A NaN is quiet when mantissa bit `MANT_W-2` is 1 and signalling when it is 0. When both operands are NaN and only operand a is signalling, operand a becomes primary.
- R2: If the primary operand is NaN, the result is NaN. It carries the primary operand's exponent and mantissa, and its sign is the XOR of both input signs.
- R3: Infinity times zero gives the default NaN: class 3, sign 0, exponent 0, and a mantissa with only bit `MANT_W-2` set.
- R4: Infinity times a number or an infinity gives infinity. It carries the primary operand's exponent and mantissa, and its sign is the XOR of the input signs.
- R5: Zero times a zero or a number gives zero, with the XOR sign, exponent 0 and mantissa 0.
- R6: For any result in R2 to R5, `done` is high for the cycle right after the edge that samples `start`. `busy` stays low, and the sticky output is 0.
- R7: For two numbers with mantissas X and Y, let P = X*Y. The result has class 1, the XOR sign and mantissa floor(P / 2^(MANT_W-1)). If that value reaches 2^MANT_W, it is shifted right once more and the exponent gains 1. The exponent is ea+eb (plus that 1), taken modulo 2^EXP_W.
- R8: The sticky output of a number product is the OR of every product bit discarded by R7, including the bit lost in the extra shift.
- R9: For a number product, count the edge that samples `start` as edge 1. `done` is high after edge 2+S, where S is the number of stepping cycles. The lowest word adds 1 if it is zero, otherwise 32-`GR_W`. Each middle word adds 1 if it is zero, otherwise 32. The top word adds ((`MANT_W`-1) mod 32)+1.
- R10: A `start` seen while `busy` is high is ignored, and the running product completes with its own operands.
- R11: After reset, `busy` and `done` are low and every result output is zero.
- R12: A number result always has mantissa bit `MANT_W-1` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a multiply when idle |
| a_cls | input | 2 | Operand a class |
| a_sign | input | 1 | Operand a sign |
| a_exp | input | EXP_W | Operand a exponent (two's complement) |
| a_mant | input | MANT_W | Operand a mantissa |
| b_cls | input | 2 | Operand b class |
| b_sign | input | 1 | Operand b sign |
| b_exp | input | EXP_W | Operand b exponent |
| b_mant | input | MANT_W | Operand b mantissa |
| busy | output | 1 | A number product is in progress |
| done | output | 1 | One-cycle result-valid pulse |
| r_cls | output | 2 | Result class |
| r_sign | output | 1 | Result sign |
| r_exp | output | EXP_W | Result exponent |
| r_mant | output | MANT_W | Result mantissa |
| r_sticky | output | 1 | OR of discarded product bits |

## Verification
Two events can meet in one cycle, and both need a test. The first is the final bit step together with the carry into the second integer bit, which forces the one-place normalising shift. Its sticky capture must be merged with the bits already folded in during the word skips. The bench provokes this with all-ones mantissas and with random multipliers whose low or middle word is zero. It judges the exponent increment and the sticky bit against a full-width product computed in the bench. The second is a new `start` arriving in a cycle where the block is busy. The bench holds `start` high with different operands during a run and expects the result, and the cycle count, of the first operands.

// File: rtl/fmul_pkg.sv
// Shared types for the shift-add multiplier.
// Assumes: class ranking is encoded so that a larger code has higher precedence.
package fmul_pkg;
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fcls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_NORM = 2'd2
    } fstate_e;
endpackage

// File: rtl/fmul_order.sv
// Orders two operands by class precedence and resolves special-operand results.
// Assumes: NaN quietness is mantissa bit MANT_W-2; purely combinational.
module fmul_order
    import fmul_pkg::*;
#(
    parameter int MANT_W = 96,
    parameter int EXP_W  = 16
) (
    input  logic [1:0]        a_cls,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [MANT_W-1:0] a_mant,
    input  logic [1:0]        b_cls,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [MANT_W-1:0] b_mant,
    output logic              special,
    output logic [1:0]        sp_cls,
    output logic              sp_sign,
    output logic [EXP_W-1:0]  sp_exp,
    output logic [MANT_W-1:0] sp_mant,
    output logic [EXP_W-1:0]  exp_sum,
    output logic [MANT_W-1:0] mcand,
    output logic [MANT_W-1:0] mplier,
    output logic              prod_sign
);
    localparam logic [MANT_W-1:0] DEF_NAN_MANT = {2'b01, {(MANT_W-2){1'b0}}};

    logic              swap;
    logic [1:0]        x_cls, y_cls;
    logic [EXP_W-1:0]  y_exp;
    logic [MANT_W-1:0] y_mant;

    // Pick the primary operand: higher class wins, lone signalling NaN wins a tie.
    always_comb begin
        swap = (a_cls > b_cls) ||
               ((a_cls == CLS_NAN) && (b_cls == CLS_NAN) &&
                !a_mant[MANT_W-2] && b_mant[MANT_W-2]);
        x_cls  = swap ? b_cls  : a_cls;
        y_cls  = swap ? a_cls  : b_cls;
        y_exp  = swap ? a_exp  : b_exp;
        y_mant = swap ? a_mant : b_mant;
        mcand  = swap ? b_mant : a_mant;
        mplier = y_mant;
        prod_sign = a_sign ^ b_sign;
        exp_sum   = a_exp + b_exp;
    end

    // Resolve the non-arithmetic outcomes in precedence order.
    always_comb begin
        special = !((x_cls == CLS_NUM) && (y_cls == CLS_NUM));
        sp_cls  = CLS_ZERO;
        sp_sign = prod_sign;
        sp_exp  = '0;
        sp_mant = '0;
        if (y_cls == CLS_NAN) begin
            sp_cls  = CLS_NAN;
            sp_exp  = y_exp;
            sp_mant = y_mant;
        end else if (y_cls == CLS_INF) begin
            if (x_cls == CLS_ZERO) begin
                sp_cls  = CLS_NAN;
                sp_sign = 1'b0;
                sp_mant = DEF_NAN_MANT;
            end else begin
                sp_cls  = CLS_INF;
                sp_exp  = y_exp;
                sp_mant = y_mant;
            end
        end
    end
endmodule

// File: rtl/fmul_accum.sv
// Radix-2 shift-add accumulator with zero-word skipping and one-step normalisation.
// Assumes: multiplier bit MANT_W-1 set, low GR_W bits zero, GR_W < 32.
module fmul_accum #(
    parameter int MANT_W = 96,
    parameter int GR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [MANT_W-1:0] mcand,
    input  logic [MANT_W-1:0] mplier,
    output logic              fin,
    output logic [MANT_W-1:0] norm_mant,
    output logic              norm_sticky,
    output logic              norm_inc
);
    localparam int WORD_W = 32;
    localparam int NW     = (MANT_W + WORD_W - 1) / WORD_W;
    localparam int WI_W   = (NW > 1) ? $clog2(NW) : 1;
    localparam int YP_W   = NW * WORD_W;
    localparam int ACC_W  = MANT_W + 1;
    localparam int TOP_BI = (MANT_W - 1) % WORD_W;

    logic [ACC_W-1:0]  acc_q;
    logic              sticky_q;
    logic [MANT_W-1:0] x_q;
    logic [YP_W-1:0]   y_q;
    logic [WI_W-1:0]   wi_q;
    logic [4:0]        bi_q;
    logic [WORD_W-1:0] word_val;
    logic              is_top, skip, cur_bit;
    logic [ACC_W-1:0]  addend;

    // Select the active multiplier word and decide skip or bit step.
    always_comb begin
        word_val = y_q[{wi_q, 5'd0} +: WORD_W];
        is_top   = (wi_q == WI_W'(NW - 1));
        skip     = !is_top && (word_val == '0);
        cur_bit  = word_val[bi_q];
        fin      = is_top && (bi_q == 5'(TOP_BI));
        addend   = cur_bit ? {1'b0, x_q} : '0;
    end

    // Accumulator, sticky and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            sticky_q <= 1'b0;
            x_q      <= '0;
            y_q      <= '0;
            wi_q     <= '0;
            bi_q     <= '0;
        end else if (load) begin
            acc_q    <= '0;
            sticky_q <= 1'b0;
            x_q      <= mcand;
            y_q      <= YP_W'(mplier);
            wi_q     <= '0;
            bi_q     <= 5'(GR_W);
        end else if (step) begin
            if (skip) begin
                if (wi_q != '0) begin
                    acc_q    <= acc_q >> WORD_W;
                    sticky_q <= sticky_q | (|acc_q[WORD_W-1:0]);
                end
                wi_q <= wi_q + WI_W'(1);
                bi_q <= '0;
            end else begin
                acc_q    <= (acc_q >> 1) + addend;
                sticky_q <= sticky_q | acc_q[0];
                if (bi_q == 5'd31) begin
                    wi_q <= wi_q + WI_W'(1);
                    bi_q <= '0;
                end else begin
                    bi_q <= bi_q + 5'd1;
                end
            end
        end
    end

    // Normalise a product in [1,4) by at most one place.
    always_comb begin
        norm_inc    = acc_q[MANT_W];
        norm_mant   = norm_inc ? acc_q[MANT_W:1] : acc_q[MANT_W-1:0];
        norm_sticky = sticky_q | (norm_inc & acc_q[0]);
    end

    // Once set, sticky survives every further step (R8).
    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sticky_q) |=> sticky_q);

    // Product of two normalised mantissas is at least one (R7).
    assert_product_ge_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && fin) |=> (acc_q[MANT_W] | acc_q[MANT_W-1]));
endmodule

// File: rtl/fp_shiftadd_mul.sv
// Top: start/busy/done control around the ordering logic and the accumulator.
// Assumes: number operands are normalised with zero guard/round bits.
module fp_shiftadd_mul
    import fmul_pkg::*;
#(
    parameter int MANT_W = 96,
    parameter int EXP_W  = 16,
    parameter int GR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        a_cls,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [MANT_W-1:0] a_mant,
    input  logic [1:0]        b_cls,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [MANT_W-1:0] b_mant,
    output logic              busy,
    output logic              done,
    output logic [1:0]        r_cls,
    output logic              r_sign,
    output logic [EXP_W-1:0]  r_exp,
    output logic [MANT_W-1:0] r_mant,
    output logic              r_sticky
);
    fstate_e           state_q;
    logic              special, sp_sign, prod_sign;
    logic [1:0]        sp_cls;
    logic [EXP_W-1:0]  sp_exp, exp_sum, exp_q;
    logic [MANT_W-1:0] sp_mant, mcand, mplier, norm_mant;
    logic              sign_q, fin, norm_sticky, norm_inc, load, step;

    fmul_order #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_order (
        .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .special(special), .sp_cls(sp_cls), .sp_sign(sp_sign),
        .sp_exp(sp_exp), .sp_mant(sp_mant), .exp_sum(exp_sum),
        .mcand(mcand), .mplier(mplier), .prod_sign(prod_sign)
    );

    fmul_accum #(.MANT_W(MANT_W), .GR_W(GR_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .mcand(mcand), .mplier(mplier), .fin(fin),
        .norm_mant(norm_mant), .norm_sticky(norm_sticky), .norm_inc(norm_inc)
    );

    // Handshake decode.
    always_comb begin
        busy = (state_q != ST_IDLE);
        load = (state_q == ST_IDLE) && start && !special;
        step = (state_q == ST_RUN);
    end

    // Control sequence and registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            done     <= 1'b0;
            sign_q   <= 1'b0;
            exp_q    <= '0;
            r_cls    <= '0;
            r_sign   <= 1'b0;
            r_exp    <= '0;
            r_mant   <= '0;
            r_sticky <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    if (special) begin
                        r_cls    <= sp_cls;
                        r_sign   <= sp_sign;
                        r_exp    <= sp_exp;
                        r_mant   <= sp_mant;
                        r_sticky <= 1'b0;
                        done     <= 1'b1;
                    end else begin
                        sign_q  <= prod_sign;
                        exp_q   <= exp_sum;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: if (fin) state_q <= ST_NORM;
                ST_NORM: begin
                    r_cls    <= CLS_NUM;
                    r_sign   <= sign_q;
                    r_exp    <= exp_q + EXP_W'(norm_inc);
                    r_mant   <= norm_mant;
                    r_sticky <= norm_sticky;
                    done     <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // A result is never flagged while the block still works (R6).
    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // Special operands finish in one cycle without entering the loop (R6).
    assert_special_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && special) |=> (done && !busy && !r_sticky));

    // Number results leave normalised (R12).
    assert_norm_top_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_cls == CLS_NUM) |-> r_mant[MANT_W-1]);

    // A start while busy does not restart the sequence (R10).
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !fin) |=> (state_q == ST_RUN || state_q == ST_NORM));
endmodule

// File: tb/fp_shiftadd_mul_test.sv
module fp_shiftadd_mul_test;
    localparam int MW = 96;
    localparam int EW = 16;
    localparam int GR = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] a_cls = '0, b_cls = '0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [EW-1:0] a_exp = '0, b_exp = '0;
    logic [MW-1:0] a_mant = '0, b_mant = '0;
    logic busy, done, r_sign, r_sticky;
    logic [1:0] r_cls;
    logic [EW-1:0] r_exp;
    logic [MW-1:0] r_mant;

    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fp_shiftadd_mul #(.MANT_W(MW), .EXP_W(EW), .GR_W(GR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .busy(busy), .done(done), .r_cls(r_cls), .r_sign(r_sign),
        .r_exp(r_exp), .r_mant(r_mant), .r_sticky(r_sticky)
    );

    // expected-result fields
    logic [1:0] e_cls;
    logic e_sign, e_sticky;
    logic [EW-1:0] e_exp;
    logic [MW-1:0] e_mant;
    int e_lat;

    function automatic logic [MW-1:0] rnd_mant();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    function automatic logic [MW-1:0] num_mant(input int zmode);
        logic [MW-1:0] m = rnd_mant();
        m[MW-1] = 1'b1;
        m[GR-1:0] = '0;
        if (zmode == 1 || zmode == 3) m[31:0] = '0;
        if (zmode == 2 || zmode == 3) m[63:32] = '0;
        return m;
    endfunction

    // Reference: independent of the RTL structure.
    task automatic model();
        logic swap;
        logic [1:0] xc, yc;
        logic [EW-1:0] ye;
        logic [MW-1:0] ym;
        logic [2*MW-1:0] p;
        logic [MW:0] acc;
        swap = (a_cls > b_cls) || (a_cls == 2'd3 && b_cls == 2'd3 && !a_mant[MW-2] && b_mant[MW-2]);
        xc = swap ? b_cls : a_cls;
        yc = swap ? a_cls : b_cls;
        ye = swap ? a_exp : b_exp;
        ym = swap ? a_mant : b_mant;
        e_sign = a_sign ^ b_sign;
        e_sticky = 1'b0;
        e_lat = 1;
        e_exp = '0;
        e_mant = '0;
        if (yc == 2'd3) begin
            e_cls = 2'd3; e_exp = ye; e_mant = ym;
        end else if (yc == 2'd2 && xc == 2'd0) begin
            e_cls = 2'd3; e_sign = 1'b0; e_mant = '0; e_mant[MW-2] = 1'b1;
        end else if (yc == 2'd2) begin
            e_cls = 2'd2; e_exp = ye; e_mant = ym;
        end else if (xc == 2'd0) begin
            e_cls = 2'd0;
        end else begin
            e_cls = 2'd1;
            p = {{MW{1'b0}}, a_mant} * {{MW{1'b0}}, b_mant};
            acc = p[2*MW-1:MW-1];
            e_sticky = |p[MW-2:0];
            e_exp = a_exp + b_exp;
            if (acc[MW]) begin
                e_sticky = e_sticky | acc[0];
                e_mant = acc[MW:1];
                e_exp = e_exp + 1'b1;
            end else begin
                e_mant = acc[MW-1:0];
            end
            e_lat = 2 + ((b_mant[31:0] == 0) ? 1 : 32 - GR)
                      + ((b_mant[63:32] == 0) ? 1 : 32) + 32;
        end
    endtask

    task automatic chk(input string tag, input logic ok, input string act, input string exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Run one operation; hold_other>0 keeps start high with other operands while busy.
    task automatic run_op(input string tag, input int hold_other);
        int cnt;
        model();
        @(negedge clk);
        start = 1'b1;
        cnt = 0;
        do begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt <= hold_other) begin
                start = 1'b1;
                a_mant = num_mant(0); b_mant = num_mant(0); a_exp = EW'($urandom());
            end else start = 1'b0;
        end while (!done && cnt < 400);
        chk({tag, " result"},
            done && r_cls == e_cls && r_sign == e_sign && r_exp == e_exp &&
            r_mant == e_mant && r_sticky == e_sticky,
            $sformatf("d%0b c%0d s%0b e%h m%h st%0b", done, r_cls, r_sign, r_exp, r_mant, r_sticky),
            $sformatf("d1 c%0d s%0b e%h m%h st%0b", e_cls, e_sign, e_exp, e_mant, e_sticky));
        chk({tag, " latency R9/R6"}, cnt == e_lat && !busy,
            $sformatf("%0d busy%0b", cnt, busy), $sformatf("%0d busy0", e_lat));
        start = 1'b0;
    endtask

    task automatic set_op(input logic [1:0] ac, input logic [1:0] bc);
        a_cls = ac; b_cls = bc;
        a_sign = 1'($urandom()); b_sign = 1'($urandom());
        a_exp = EW'($urandom()); b_exp = EW'($urandom());
        a_mant = (ac == 2'd1) ? num_mant(int'($urandom() % 4)) : rnd_mant();
        b_mant = (bc == 2'd1) ? num_mant(int'($urandom() % 4)) : rnd_mant();
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset", !busy && !done && r_cls == 0 && !r_sign && r_exp == 0 && r_mant == 0 && !r_sticky,
            $sformatf("b%0b d%0b c%0d", busy, done, r_cls), "all zero");

        // every class pair: R1..R5, R7
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                set_op(2'(i), 2'(j));
                run_op($sformatf("R1-pair a%0d b%0d (R2 R3 R4 R5 R7)", i, j), 0);
            end

        // signalling-NaN ordering R1/R2
        set_op(2'd3, 2'd3); a_mant[MW-2] = 1'b0; b_mant[MW-2] = 1'b1; run_op("R1 snan-a R2", 0);
        set_op(2'd3, 2'd3); a_mant[MW-2] = 1'b1; b_mant[MW-2] = 1'b0; run_op("R1 snan-b R2", 0);
        set_op(2'd3, 2'd3); a_mant[MW-2] = 1'b0; b_mant[MW-2] = 1'b0; run_op("R1 both-snan R2", 0);
        set_op(2'd2, 2'd0); run_op("R3 inf-zero", 0);
        set_op(2'd0, 2'd2); run_op("R3 zero-inf", 0);

        // largest mantissas: extra shift, R7 R8 R12
        set_op(2'd1, 2'd1);
        a_mant = '1; a_mant[GR-1:0] = '0; b_mant = a_mant;
        run_op("R7 R8 R12 max-mant", 0);
        // exact one times one: no shift, no sticky
        set_op(2'd1, 2'd1);
        a_mant = '0; a_mant[MW-1] = 1'b1; b_mant = a_mant;
        a_exp = 16'h7fff; b_exp = 16'h0001;
        run_op("R7 R8 unit exp-wrap", 0);
        // both low words zero: double skip, R9
        set_op(2'd1, 2'd1); b_mant = num_mant(3); run_op("R9 R8 two-skip", 0);
        set_op(2'd1, 2'd1); b_mant = num_mant(2); run_op("R9 R8 mid-skip", 0);

        // start while busy: R10
        set_op(2'd1, 2'd1); b_mant = num_mant(0); run_op("R10 restart-ignored", 5);

        // random numbers and classes
        for (int k = 0; k < 250; k++) begin
            set_op(2'd1, 2'd1);
            run_op("R7 R8 R9 R12 random", 0);
        end
        for (int k = 0; k < 60; k++) begin
            set_op(2'($urandom()), 2'($urandom()));
            run_op("R1 R6 random-class", 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule